// File: doc/BRIEF.md
# Saturating Bidirectional Arithmetic Shifter

This block is the 32-bit signed shift unit of a DSP-style datapath. Each accepted operation takes a source word, a shift-amount word and an instruction-mode bit. The mode bit selects between a right-shift and a left-shift instruction. The low seven bits of the amount word form a signed count. A negative count turns the shift around, so each instruction can move the source in either direction.

Every left shift is saturating. The source is widened to 64 bits and shifted there. A result that leaves the signed 32-bit range is clamped, and so is a positive source whose bits are all pushed out. Right shifts are arithmetic and never saturate. The result is registered one cycle after the request and comes with a one-cycle valid strobe. A sticky overflow bit records any saturation and stays set until the clear input is asserted.

Top module: `sat_shift_unit`

## Requirements
- R1: The shift count is bits [6:0] of `amt`, read as a two's-complement value from -64 to +63. Bits [31:7] of `amt` have no effect on the result or on the overflow bit.
- R2: With `mode_left`=0, a count of zero or more shifts `src` right arithmetically. A negative count shifts it left, saturating, by the count's magnitude.
- R3: With `mode_left`=1, a count of zero or more shifts `src` left, saturating. A negative count shifts it right arithmetically by the count's magnitude.
- R4: A left shift is done on `src` sign-extended to 64 bits. The result is saturated and overflow is set in two cases: the 64-bit value leaves the signed 32-bit range, or the clamped value's sign differs from the sign of `src`. The saturation value is 0x7FFFFFFF for a non-negative `src` and 0x80000000 for a negative `src`.
- R5: If `src` is positive and the 64-bit shifted value is zero, the result is 0x7FFFFFFF and overflow is set.
- R6: A right shift never sets overflow. A right shift by 32 or more gives 32 copies of the sign bit of `src`.
- R7: A left shift whose value fits the signed 32-bit range and keeps its sign gives the exact product with no overflow. This includes a zero `src` shifted by any amount.
- R8: `result` and `out_valid` appear on the clock edge after the edge that samples `in_valid`=1. `out_valid` is high for exactly one cycle per request, and `result` holds its value while no request is accepted.
- R9: `ovf_sticky` is set by a saturating accepted operation and stays set until `ovf_clr` is asserted. When a clear and a set fall in the same cycle, the clear wins.
- R10: While `rst_n` is low, `out_valid`, `result` and `ovf_sticky` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe; operands sampled when high |
| src | input | 32 | Signed source operand |
| amt | input | 32 | Shift-amount operand; bits [6:0] used as a signed count |
| mode_left | input | 1 | 0 = right-shift instruction, 1 = left-shift instruction |
| ovf_clr | input | 1 | Clears the sticky overflow bit (priority over set) |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| result | output | 32 | Registered shift result |
| ovf_sticky | output | 1 | Sticky saturation flag |

## Verification
The bound checker watches several rules on every cycle:
- the request-to-strobe timing and the holding of `result` between requests;
- the stickiness of the overflow bit and the priority of the clear;
- that a right shift with a non-negative count never raises overflow;
- that any newly raised overflow comes with one of the two saturation values.

Which saturation value is right, the rule for a positive source shifted out to zero, the arithmetic fill for long right shifts and the masking of the upper amount bits all depend on exact operand values. Only the bench's vector table and directed cases can show those.

// File: rtl/sat_shift_pkg.sv
package sat_shift_pkg;

  // Instruction flavour carried by the mode input
  typedef enum logic {
    INSTR_SHR = 1'b0,
    INSTR_SHL = 1'b1
  } instr_mode_e;

  // Physical direction after the count sign is applied
  typedef enum logic {
    PATH_RIGHT = 1'b0,
    PATH_LEFT  = 1'b1
  } shift_path_e;

  // Saturation word for a given source sign
  function automatic logic [31:0] sat_word32(input logic neg);
    return neg ? 32'h8000_0000 : 32'h7FFF_FFFF;
  endfunction

endpackage

// File: rtl/shift_count_decode.sv
module shift_count_decode
  import sat_shift_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic [CW-1:0] cnt_raw,
  input  instr_mode_e   mode,
  output shift_path_e   path,
  output logic [CW-1:0] mag
);

  logic neg;

  always_comb begin
    neg = cnt_raw[CW-1];
    // Magnitude of the most negative count still fits as unsigned CW bits
    mag = neg ? (~cnt_raw + {{(CW-1){1'b0}}, 1'b1}) : cnt_raw;
    if ((mode == INSTR_SHL) ^ neg) begin
      path = PATH_LEFT;
    end else begin
      path = PATH_RIGHT;
    end
  end

endmodule

// File: rtl/shift_right_arith.sv
module shift_right_arith #(
  parameter int W  = 32,
  parameter int CW = 7
) (
  input  logic [W-1:0]  din,
  input  logic [CW-1:0] mag,
  output logic [W-1:0]  dout
);

  logic [W-1:0] stage [CW+1];
  logic         sgn;

  assign sgn      = din[W-1];
  assign stage[0] = din;

  for (genvar i = 0; i < CW; i++) begin : g_stage
    localparam int STEP = 1 << i;
    if (STEP >= W) begin : g_fill
      assign stage[i+1] = mag[i] ? {W{sgn}} : stage[i];
    end else begin : g_part
      assign stage[i+1] = mag[i] ? {{STEP{sgn}}, stage[i][W-1:STEP]} : stage[i];
    end
  end

  assign dout = stage[CW];

endmodule

// File: rtl/shift_left_sat.sv
module shift_left_sat #(
  parameter int W  = 32,
  parameter int CW = 7
) (
  input  logic [W-1:0]  din,
  input  logic [CW-1:0] mag,
  output logic [W-1:0]  dout,
  output logic          sat
);

  localparam int WW = 2 * W;
  localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

  logic [WW-1:0] wide;
  logic [WW-1:0] shl;
  logic [W:0]    upper;
  logic          fits;
  logic [W-1:0]  clamped;
  logic [W-1:0]  satv;
  logic          sign_flip;
  logic          src_pos;
  logic          all_out;

  always_comb begin
    wide    = {{W{din[W-1]}}, din};
    shl     = wide << mag;
    upper   = shl[WW-1:W-1];
    fits    = (&upper) | ~(|upper);
    clamped = fits ? shl[W-1:0] : (shl[WW-1] ? NEG_MIN : POS_MAX);
    satv    = din[W-1] ? NEG_MIN : POS_MAX;

    sign_flip = clamped[W-1] ^ din[W-1];
    src_pos   = ~din[W-1] & (|din);
    all_out   = ~(|shl);

    if (sign_flip) begin
      dout = satv;
      sat  = 1'b1;
    end else if (src_pos && all_out) begin
      dout = POS_MAX;
      sat  = 1'b1;
    end else begin
      dout = clamped;
      sat  = ~fits;
    end
  end

endmodule

// File: rtl/sat_shift_unit.sv
module sat_shift_unit
  import sat_shift_pkg::*;
#(
  parameter int W  = 32,
  parameter int CW = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] src,
  input  logic [W-1:0] amt,
  input  logic         mode_left,
  input  logic         ovf_clr,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         ovf_sticky
);

  shift_path_e   path;
  logic [CW-1:0] mag;
  logic [W-1:0]  rsh_val;
  logic [W-1:0]  lsh_val;
  logic          lsh_sat;
  logic          amt_hi_unused;

  logic [W-1:0]  result_d, result_q;
  logic          valid_d, valid_q;
  logic          ovf_d, ovf_q;
  logic          op_sat;

  assign amt_hi_unused = ^amt[W-1:CW];

  shift_count_decode #(.CW(CW)) u_decode (
    .cnt_raw (amt[CW-1:0]),
    .mode    (instr_mode_e'(mode_left)),
    .path    (path),
    .mag     (mag)
  );

  shift_right_arith #(.W(W), .CW(CW)) u_rsh (
    .din  (src),
    .mag  (mag),
    .dout (rsh_val)
  );

  shift_left_sat #(.W(W), .CW(CW)) u_lsh (
    .din  (src),
    .mag  (mag),
    .dout (lsh_val),
    .sat  (lsh_sat)
  );

  // Next-state logic
  always_comb begin
    op_sat   = (path == PATH_LEFT) & lsh_sat;
    result_d = result_q;
    if (in_valid) begin
      result_d = (path == PATH_LEFT) ? lsh_val : rsh_val;
    end
    valid_d = in_valid;
    if (ovf_clr) begin
      ovf_d = 1'b0;
    end else begin
      ovf_d = ovf_q | (in_valid & op_sat);
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      valid_q  <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      result_q <= result_d;
      valid_q  <= valid_d;
      ovf_q    <= ovf_d;
    end
  end

  assign out_valid  = valid_q;
  assign result     = result_q;
  assign ovf_sticky = ovf_q;

endmodule

// File: rtl/sat_shift_unit_chk.sv
module sat_shift_unit_chk #(
  parameter int W  = 32,
  parameter int CW = 7
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [W-1:0] src,
  input logic [W-1:0] amt,
  input logic         mode_left,
  input logic         ovf_clr,
  input logic         out_valid,
  input logic [W-1:0] result,
  input logic         ovf_sticky
);

  localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

  logic src_unused;
  assign src_unused = ^src;

  // R8: a request gives a strobe on the next edge
  assert_strobe_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R8: no request, no strobe
  assert_no_spurious_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R8: result holds between requests
  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));

  // R9: clear wins over any set
  assert_clear_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_clr |=> !ovf_sticky);

  // R9: flag is sticky without a clear
  assert_sticky_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_sticky && !ovf_clr) |=> ovf_sticky);

  // R9: flag only rises on an accepted request
  assert_set_needs_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf_sticky && !in_valid) |=> !ovf_sticky);

  // R6: right instruction with non-negative count never overflows
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !ovf_clr && !ovf_sticky && !mode_left && !amt[CW-1]) |=> !ovf_sticky);

  // R4: a fresh overflow comes with a saturation word
  assert_sat_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_sticky) |-> (result == POS_MAX || result == NEG_MIN));

  // R10: reset values
  always_comb begin
    if (!rst_n) begin
      assert_reset_state_R10: assert (!out_valid && !ovf_sticky && result == '0);
    end
  end

endmodule

bind sat_shift_unit sat_shift_unit_chk #(.W(W), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .src        (src),
  .amt        (amt),
  .mode_left  (mode_left),
  .ovf_clr    (ovf_clr),
  .out_valid  (out_valid),
  .result     (result),
  .ovf_sticky (ovf_sticky)
);

// File: tb/test_sat_shift_unit.sv
`timescale 1ns/1ps
module test_sat_shift_unit;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] src;
  logic [31:0] amt;
  logic        mode_left;
  logic        ovf_clr;
  logic        out_valid;
  logic [31:0] result;
  logic        ovf_sticky;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  sat_shift_unit i_sat_shift_unit (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .src        (src),
    .amt        (amt),
    .mode_left  (mode_left),
    .ovf_clr    (ovf_clr),
    .out_valid  (out_valid),
    .result     (result),
    .ovf_sticky (ovf_sticky)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Vector fields: [101:98] req, [97] mode, [96:65] src, [64:33] amt, [32:1] expected, [0] overflow
  localparam int NV = 26;
  localparam logic [101:0] VECS [NV] = '{
    {4'd2, 1'b0, 32'h0000FFFF, 32'h00000002, 32'h00003FFF, 1'b0}, // R2
    {4'd2, 1'b0, 32'h80000000, 32'h00000001, 32'hC0000000, 1'b0}, // R2
    {4'd2, 1'b0, 32'hFFFFFFFF, 32'h00000001, 32'hFFFFFFFF, 1'b0}, // R2
    {4'd2, 1'b0, 32'h00FFFFFF, 32'h000000F5, 32'h7FFFFFFF, 1'b1}, // R2
    {4'd2, 1'b0, 32'h80000000, 32'h000000F5, 32'h80000000, 1'b1}, // R2
    {4'd5, 1'b0, 32'h7FFF0000, 32'h00000042, 32'h7FFFFFFF, 1'b1}, // R5
    {4'd4, 1'b0, 32'hFF000000, 32'h00000042, 32'h80000000, 1'b1}, // R4
    {4'd3, 1'b1, 32'h00000000, 32'h00000040, 32'h00000000, 1'b0}, // R3
    {4'd3, 1'b1, 32'h80000000, 32'h000000FF, 32'hC0000000, 1'b0}, // R3
    {4'd3, 1'b1, 32'hFFFFFFFF, 32'h000000FF, 32'hFFFFFFFF, 1'b0}, // R3
    {4'd3, 1'b1, 32'h00FFFFFF, 32'h0000000B, 32'h7FFFFFFF, 1'b1}, // R3
    {4'd3, 1'b1, 32'h80000000, 32'h0000000B, 32'h80000000, 1'b1}, // R3
    {4'd5, 1'b1, 32'h7FFF0000, 32'h000000BE, 32'h7FFFFFFF, 1'b1}, // R5
    {4'd4, 1'b1, 32'hFF000000, 32'h000000BE, 32'h80000000, 1'b1}, // R4
    {4'd1, 1'b0, 32'h0000FFFF, 32'hABCDEF02, 32'h00003FFF, 1'b0}, // R1
    {4'd7, 1'b1, 32'h00001234, 32'h00000004, 32'h00012340, 1'b0}, // R7
    {4'd7, 1'b1, 32'hFFFFFFFF, 32'h00000001, 32'hFFFFFFFE, 1'b0}, // R7
    {4'd6, 1'b0, 32'h12345678, 32'h00000020, 32'h00000000, 1'b0}, // R6
    {4'd6, 1'b0, 32'h87654321, 32'h0000003F, 32'hFFFFFFFF, 1'b0}, // R6
    {4'd6, 1'b1, 32'h87654321, 32'h000000C0, 32'hFFFFFFFF, 1'b0}, // R6
    {4'd4, 1'b1, 32'h00000001, 32'h0000001F, 32'h7FFFFFFF, 1'b1}, // R4
    {4'd7, 1'b1, 32'h00000001, 32'h0000001E, 32'h40000000, 1'b0}, // R7
    {4'd7, 1'b1, 32'hFFFFFFFF, 32'h0000001F, 32'h80000000, 1'b0}, // R7
    {4'd7, 1'b1, 32'h00000000, 32'h0000003F, 32'h00000000, 1'b0}, // R7
    {4'd4, 1'b1, 32'h00000001, 32'h0000003F, 32'h7FFFFFFF, 1'b1}, // R4
    {4'd2, 1'b0, 32'h40000000, 32'h0000007F, 32'h7FFFFFFF, 1'b1}  // R2
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic clear_flag();
    @(negedge clk);
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
  endtask

  // One request; on return the registered outputs are stable
  task automatic issue(input logic m, input logic [31:0] s, input logic [31:0] a);
    @(negedge clk);
    mode_left = m;
    src       = s;
    amt       = a;
    in_valid  = 1'b1;
    @(negedge clk);
    in_valid  = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    src       = '0;
    amt       = '0;
    mode_left = 1'b0;
    ovf_clr   = 1'b0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 out_valid", {31'd0, out_valid}, 32'd0);
    check("R10 result", result, 32'd0);
    check("R10 ovf_sticky", {31'd0, ovf_sticky}, 32'd0);
    rst_n = 1'b1;

    // Table walk
    for (int i = 0; i < NV; i++) begin
      clear_flag();
      issue(VECS[i][97], VECS[i][96:65], VECS[i][64:33]);
      check($sformatf("R%0d result vec%0d", VECS[i][101:98], i), result, VECS[i][32:1]);
      check($sformatf("R%0d overflow vec%0d", VECS[i][101:98], i),
            {31'd0, ovf_sticky}, {31'd0, VECS[i][0]});
      check($sformatf("R8 strobe vec%0d", i), {31'd0, out_valid}, 32'd1);
    end

    // R8: strobe lasts one cycle and result holds while idle
    @(negedge clk);
    check("R8 strobe drops", {31'd0, out_valid}, 32'd0);
    src = 32'h0000_0F00;
    amt = 32'h0000_0001;
    repeat (3) @(negedge clk);
    check("R8 result hold", result, 32'h7FFF_FFFF);

    // R9: sticky across clean ops
    clear_flag();
    issue(1'b1, 32'h0000_0001, 32'h0000_0020);
    check("R9 set", {31'd0, ovf_sticky}, 32'd1);
    issue(1'b0, 32'h0000_0100, 32'h0000_0004);
    check("R9 clean op result", result, 32'h0000_0010);
    check("R9 stays set", {31'd0, ovf_sticky}, 32'd1);

    // R9: clear in same cycle as a saturating request
    @(negedge clk);
    mode_left = 1'b1;
    src       = 32'h7000_0000;
    amt       = 32'h0000_0004;
    in_valid  = 1'b1;
    ovf_clr   = 1'b1;
    @(negedge clk);
    in_valid  = 1'b0;
    ovf_clr   = 1'b0;
    check("R9 clear priority flag", {31'd0, ovf_sticky}, 32'd0);
    check("R4 result under clear", result, 32'h7FFF_FFFF);

    // R1: upper amount bits do not reach the overflow path
    clear_flag();
    issue(1'b0, 32'h0000_0001, 32'hFFFF_FF01);
    check("R1 upper bits result", result, 32'h0000_0000);
    check("R1 upper bits flag", {31'd0, ovf_sticky}, 32'd0);

    // R10: reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 reset result", result, 32'd0);
    check("R10 reset flag", {31'd0, ovf_sticky}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    finish_run();
  end

endmodule